// File: doc/BRIEF.md
# Touch Toggle Controller with Timed Auto-Off

This block sits behind a capacitive touch front end that already confirms touches. Each confirmed touch flips a single logical on/off state. The block drives that state onto a pin whose active level is chosen by a polarity strap. While the state is on, a countdown can switch it off by itself after a chosen delay. The delay is picked by a two-bit strap from a small preset set, or it is supplied as a digital tick count. A x1 / x24 multiplier strap, captured only during reset, scales the delay.

A single override line handles both sustain and cancel. The block compares its synchronized level with the multiplier strap level captured at reset, and measures how long it stays away from that rest level in 1 ms ticks:
- A medium-length excursion restarts the countdown at the next burst boundary.
- A long excursion forces the output off, blocks touches and raises a burst-inhibit flag until the line returns to rest. On that return the block issues a one-cycle recalibration request.

All delays are counted in enable ticks, so a bench can shrink them.

Top module: `touch_toggle_autooff`

## Requirements
- R1: A touch pulse (`touch_i` high for one cycle) while `inhibit_o` is low inverts the logical on state at the next clock edge.
- R2: During and right after reset the logical state is off and both `recal_o` and `inhibit_o` are low. `mult_sel_i` and the override rest level are captured while `rst_n` is low and held until the next reset.
- R3: `out_o` equals the logical on state XOR `act_low_i`, so `act_low_i`=1 makes "on" drive 0.
- R4: Preset codes on `dly_sel_i`:
  - With `act_low_i`=0: 0 gives infinite, 1 gives `T15_TICKS`, 2 gives `T60_TICKS`.
  - With `act_low_i`=1: 0 gives `T15_TICKS`, 1 gives infinite, 2 gives `T60_TICKS`.
- R5: Code 3 takes the delay from `user_dly_i`:
  - a value below `USER_MIN` acts as infinite;
  - a value above `USER_MAX` acts as `T60_TICKS`;
  - a value inside the range, including both limits, is used as is.
- R6: The delay is loaded when the state turns on. The state turns off on the Nth `sec_tick_i` pulse after turn-on, where N is the loaded delay. An infinite delay never expires.
- R7: If `mult_sel_i` was 1 during reset, every loaded delay is multiplied by `MULT_HI`.
- R8: The override is active while the synchronized `ovr_i` differs from the captured `mult_sel_i`. An active period of at least `SUSTAIN_MS` and below `CANCEL_MS` ms ticks arms a sustain. An armed sustain reloads the delay at the first `burst_done_i` after release, and only if the state is on. It does not reload before that `burst_done_i`.
- R9: An active period shorter than `SUSTAIN_MS` ms ticks has no effect on the countdown.
- R10: When an active period reaches `CANCEL_MS` ms ticks, `inhibit_o` rises, the state is forced off at the next edge, and touches are ignored while `inhibit_o` is high.
- R11: When the override returns to rest after a cancel, `inhibit_o` drops, `recal_o` pulses for exactly one cycle, and the state stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_i | input | 1 | Confirmed-touch pulse |
| dly_sel_i | input | 2 | Delay strap code |
| user_dly_i | input | USER_W | User-programmed delay in ticks |
| mult_sel_i | input | 1 | Multiplier strap, captured in reset |
| ovr_i | input | 1 | Asynchronous override level |
| act_low_i | input | 1 | Output polarity strap |
| sec_tick_i | input | 1 | Countdown enable tick |
| ms_tick_i | input | 1 | 1 ms tick for pulse-width timing |
| burst_done_i | input | 1 | End of an acquisition burst |
| out_o | output | 1 | Polarity-adjusted switched output |
| recal_o | output | 1 | One-cycle sensor recalibration request |
| inhibit_o | output | 1 | Bursts and touches are blocked |

## Verification
The countdown is run under every strap code in both polarities, with in-range, edge and out-of-range user values, and with the multiplier on and off. Each run samples one tick before and at the expected expiry, which separates a wrong preset mapping from an off-by-one count. Override pulses are applied with widths below the sustain threshold, between the two thresholds, and at the cancel threshold. Comparing the expiry tick with and without a later burst boundary shows whether a sustain is ignored, applied early or applied correctly. The cancel run also applies a touch during inhibit and counts the cycles of the recalibration pulse after release.

// File: rtl/tto_pkg.sv
package tto_pkg;

   typedef enum logic [1:0] {
      DLY_TIE_LO   = 2'd0,
      DLY_TIE_HI   = 2'd1,
      DLY_LINK_OUT = 2'd2,
      DLY_USER     = 2'd3
   } dly_sel_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tto_sync.sv
module tto_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_val_i,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tto_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[g] <= rst_val_i;
         end else begin
            if (g == 0) stage_q[g] <= d_i;
            else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/tto_ovr_decode.sv
module tto_ovr_decode #(
   parameter int unsigned SUSTAIN_MS = 25,
   parameter int unsigned CANCEL_MS  = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovr_sync_i,
   input  logic rest_lvl_i,
   input  logic ms_tick_i,
   input  logic burst_done_i,
   output logic sustain_o,
   output logic inhibit_o,
   output logic recal_o
);

   localparam int unsigned WW = $clog2(CANCEL_MS + 1);

   if (SUSTAIN_MS < 1 || CANCEL_MS <= SUSTAIN_MS) begin : g_bad_thresh
      $error("tto_ovr_decode: need 1 <= SUSTAIN_MS < CANCEL_MS");
   end

   logic          active;
   logic [WW-1:0] wcnt_q;
   logic          cancel_q;
   logic          pend_q;
   logic          recal_q;

   assign active = ovr_sync_i ^ rest_lvl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt_q   <= '0;
         cancel_q <= 1'b0;
         pend_q   <= 1'b0;
         recal_q  <= 1'b0;
      end else begin
         recal_q <= cancel_q && !active;
         if (burst_done_i) pend_q <= 1'b0;
         if (!active) begin
            wcnt_q <= '0;
            if (cancel_q)                         cancel_q <= 1'b0;
            else if (wcnt_q >= WW'(SUSTAIN_MS))   pend_q   <= 1'b1;
         end else if (ms_tick_i && (wcnt_q != WW'(CANCEL_MS))) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_q == WW'(CANCEL_MS - 1)) begin
               cancel_q <= 1'b1;
               pend_q   <= 1'b0;
            end
         end
      end
   end

   assign sustain_o = pend_q && burst_done_i;
   assign inhibit_o = cancel_q;
   assign recal_o   = recal_q;

   AST_WIDTH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_q <= WW'(CANCEL_MS)); // R10
   AST_RECAL_FOLLOWS_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recal_q) |-> $past(cancel_q)); // R11
   AST_RECAL_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
      recal_q |-> !cancel_q); // R11
   AST_NO_SUSTAIN_IN_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_q |-> !pend_q); // R8

endmodule

// File: rtl/tto_delay_sel.sv
module tto_delay_sel
   import tto_pkg::*;
#(
   parameter int unsigned T15_TICKS = 900,
   parameter int unsigned T60_TICKS = 3600,
   parameter int unsigned USER_W    = 8,
   parameter int unsigned USER_MIN  = 4,
   parameter int unsigned USER_MAX  = 240,
   parameter int unsigned MULT_HI   = 24,
   parameter int unsigned CW        = 17
) (
   input  logic [1:0]        sel_i,
   input  logic              act_low_i,
   input  logic [USER_W-1:0] user_i,
   input  logic              mult_i,
   output logic [CW-1:0]     load_o,
   output logic              inf_o
);

   dly_sel_e       sel;
   logic [CW-1:0]  base;

   assign sel = dly_sel_e'(sel_i);

   always_comb begin
      base  = '0;
      inf_o = 1'b0;
      unique case (sel)
         DLY_TIE_LO: begin
            if (!act_low_i) inf_o = 1'b1;
            else            base  = CW'(T15_TICKS);
         end
         DLY_TIE_HI: begin
            if (act_low_i) inf_o = 1'b1;
            else           base  = CW'(T15_TICKS);
         end
         DLY_LINK_OUT: base = CW'(T60_TICKS);
         DLY_USER: begin
            if (user_i < USER_W'(USER_MIN))      inf_o = 1'b1;
            else if (user_i > USER_W'(USER_MAX)) base  = CW'(T60_TICKS);
            else                                 base  = CW'(user_i);
         end
      endcase
   end

   if (MULT_HI == 1) begin : g_no_mult
      logic unused_mult;
      assign unused_mult = mult_i;
      assign load_o      = base;
   end else begin : g_mult
      assign load_o = mult_i ? CW'(base * CW'(MULT_HI)) : base;
   end

endmodule

// File: rtl/touch_toggle_autooff.sv
module touch_toggle_autooff
   import tto_pkg::*;
#(
   parameter int unsigned T15_TICKS   = 900,
   parameter int unsigned T60_TICKS   = 3600,
   parameter int unsigned USER_W      = 8,
   parameter int unsigned USER_MIN    = 4,
   parameter int unsigned USER_MAX    = 240,
   parameter int unsigned MULT_HI     = 24,
   parameter int unsigned SUSTAIN_MS  = 25,
   parameter int unsigned CANCEL_MS   = 65,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              touch_i,
   input  logic [1:0]        dly_sel_i,
   input  logic [USER_W-1:0] user_dly_i,
   input  logic              mult_sel_i,
   input  logic              ovr_i,
   input  logic              act_low_i,
   input  logic              sec_tick_i,
   input  logic              ms_tick_i,
   input  logic              burst_done_i,
   output logic              out_o,
   output logic              recal_o,
   output logic              inhibit_o
);

   localparam int unsigned MAXBASE = max_u(T60_TICKS, max_u(T15_TICKS, USER_MAX));
   localparam int unsigned CW      = $clog2(MAXBASE * MULT_HI + 1);

   if (T15_TICKS < 1 || T60_TICKS < 1 || USER_MIN < 1 || MULT_HI < 1) begin : g_bad_delay
      $error("touch_toggle_autooff: delays and multiplier must be nonzero");
   end
   if (USER_MAX >= (1 << USER_W) || USER_MIN > USER_MAX) begin : g_bad_user
      $error("touch_toggle_autooff: user range does not fit USER_W");
   end

   logic          mult_q;
   logic          ovr_sync;
   logic          sustain;
   logic [CW-1:0] load_val;
   logic          load_inf;
   logic          on_q;
   logic          inf_q;
   logic [CW-1:0] cnt_q;

   tto_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_val_i (mult_sel_i),
      .d_i       (ovr_i),
      .q_o       (ovr_sync)
   );

   tto_ovr_decode #(.SUSTAIN_MS(SUSTAIN_MS), .CANCEL_MS(CANCEL_MS)) u_ovr (
      .clk          (clk),
      .rst_n        (rst_n),
      .ovr_sync_i   (ovr_sync),
      .rest_lvl_i   (mult_q),
      .ms_tick_i    (ms_tick_i),
      .burst_done_i (burst_done_i),
      .sustain_o    (sustain),
      .inhibit_o    (inhibit_o),
      .recal_o      (recal_o)
   );

   tto_delay_sel #(
      .T15_TICKS (T15_TICKS),
      .T60_TICKS (T60_TICKS),
      .USER_W    (USER_W),
      .USER_MIN  (USER_MIN),
      .USER_MAX  (USER_MAX),
      .MULT_HI   (MULT_HI),
      .CW        (CW)
   ) u_dsel (
      .sel_i     (dly_sel_i),
      .act_low_i (act_low_i),
      .user_i    (user_dly_i),
      .mult_i    (mult_q),
      .load_o    (load_val),
      .inf_o     (load_inf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult_q <= mult_sel_i;
         on_q   <= 1'b0;
         inf_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (inhibit_o) begin
         on_q  <= 1'b0;
         cnt_q <= '0;
      end else if (touch_i) begin
         if (on_q) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
         end else begin
            on_q  <= 1'b1;
            cnt_q <= load_val;
            inf_q <= load_inf;
         end
      end else if (on_q && sustain) begin
         cnt_q <= load_val;
         inf_q <= load_inf;
      end else if (on_q && !inf_q && sec_tick_i) begin
         if (cnt_q == CW'(1)) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign out_o = on_q ^ act_low_i;

   AST_TOUCH_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_i && !inhibit_o) |=> (on_q != $past(on_q))); // R1
   AST_INHIBIT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_o |=> !on_q); // R10
   AST_INFINITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && inf_q && !touch_i && !inhibit_o) |=> on_q); // R6
   AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && !inf_q) |-> (cnt_q != '0)); // R6
   AST_RECAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      recal_o |=> !recal_o); // R11

endmodule

// File: tb/sim_touch_toggle_autooff.sv
module sim_touch_toggle_autooff;

   localparam int unsigned P_T15 = 3;
   localparam int unsigned P_T60 = 6;
   localparam int unsigned P_UW  = 8;
   localparam int unsigned P_MUL = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic touch = 1'b0;
   logic [1:0] dsel = 2'd0;
   logic [P_UW-1:0] udly = '0;
   logic mult = 1'b0;
   logic ovr = 1'b0;
   logic act_low = 1'b0;
   logic sec = 1'b0;
   logic msk = 1'b0;
   logic burst = 1'b0;
   logic out_w, recal_w, inh_w;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   touch_toggle_autooff #(
      .T15_TICKS(P_T15), .T60_TICKS(P_T60), .USER_W(P_UW), .USER_MIN(4),
      .USER_MAX(12), .MULT_HI(P_MUL), .SUSTAIN_MS(5), .CANCEL_MS(10),
      .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .touch_i(touch), .dly_sel_i(dsel),
      .user_dly_i(udly), .mult_sel_i(mult), .ovr_i(ovr), .act_low_i(act_low),
      .sec_tick_i(sec), .ms_tick_i(msk), .burst_done_i(burst),
      .out_o(out_w), .recal_o(recal_w), .inhibit_o(inh_w)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst_n = 1'b0; mult = m; ovr = m; touch = 0; sec = 0; msk = 0; burst = 0;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic touch_pulse;
      touch = 1'b1; @(negedge clk); touch = 1'b0; @(negedge clk);
   endtask

   task automatic sec_n(input int n);
      for (int i = 0; i < n; i++) begin
         sec = 1'b1; @(negedge clk); sec = 1'b0; @(negedge clk);
      end
   endtask

   task automatic ms_n(input int n);
      for (int i = 0; i < n; i++) begin
         msk = 1'b1; @(negedge clk); msk = 1'b0; @(negedge clk);
      end
   endtask

   task automatic burst_pulse;
      burst = 1'b1; @(negedge clk); burst = 1'b0; @(negedge clk);
   endtask

   // n == 0 means the delay must never expire
   task automatic run_delay(input string req, input logic [1:0] s, input logic al,
                            input int u, input int n);
      dsel = s; act_low = al; udly = P_UW'(u);
      cyc(1);
      touch_pulse();
      chk({req, " turned on"}, out_w, ~al);
      if (n == 0) begin
         sec_n(30);
         chk({req, " infinite holds"}, out_w, ~al);
         touch_pulse();
      end else begin
         sec_n(n - 1);
         chk({req, " one tick before expiry"}, out_w, ~al);
         sec_n(1);
         chk({req, " expired"}, out_w, al);
      end
      chk({req, " ends off"}, out_w, al);
   endtask

   task automatic t_reset;
      do_reset(1'b0);
      chk("R2 reset out", out_w, 1'b0);
      chk("R2 reset recal", recal_w, 1'b0);
      chk("R2 reset inhibit", inh_w, 1'b0);
   endtask

   task automatic t_toggle;
      dsel = 2'd0; act_low = 0; cyc(1);
      touch_pulse(); chk("R1 first touch on", out_w, 1'b1);
      touch_pulse(); chk("R1 second touch off", out_w, 1'b0);
      touch_pulse(); chk("R1 third touch on", out_w, 1'b1);
      touch_pulse(); chk("R1 fourth touch off", out_w, 1'b0);
   endtask

   task automatic t_polarity;
      dsel = 2'd1; act_low = 1; cyc(1);
      chk("R3 active-low off level", out_w, 1'b1);
      touch_pulse(); chk("R3 active-low on level", out_w, 1'b0);
      touch_pulse(); chk("R3 active-low back off", out_w, 1'b1);
      act_low = 0; cyc(1);
   endtask

   task automatic t_presets;
      run_delay("R4 hi code1", 2'd1, 1'b0, 0, P_T15);
      run_delay("R4 hi code2", 2'd2, 1'b0, 0, P_T60);
      run_delay("R4 hi code0", 2'd0, 1'b0, 0, 0);
      run_delay("R4 lo code0", 2'd0, 1'b1, 0, P_T15);
      run_delay("R4 lo code1", 2'd1, 1'b1, 0, 0);
      run_delay("R4 lo code2", 2'd2, 1'b1, 0, P_T60);
      run_delay("R6 expiry on countdown", 2'd1, 1'b0, 0, P_T15);
   endtask

   task automatic t_user;
      run_delay("R5 user 7", 2'd3, 1'b0, 7, 7);
      run_delay("R5 user min 4", 2'd3, 1'b0, 4, 4);
      run_delay("R5 user max 12", 2'd3, 1'b0, 12, 12);
      run_delay("R5 user below 2", 2'd3, 1'b0, 2, 0);
      run_delay("R5 user above 20", 2'd3, 1'b0, 20, P_T60);
   endtask

   task automatic t_mult;
      do_reset(1'b1);
      run_delay("R7 x24 code1", 2'd1, 1'b0, 0, P_T15 * P_MUL);
      run_delay("R7 x24 user 5", 2'd3, 1'b0, 5, 5 * P_MUL);
      do_reset(1'b0);
   endtask

   task automatic t_sustain;
      dsel = 2'd2; act_low = 0; cyc(1);
      // sustain-width pulse, reload at burst boundary
      touch_pulse(); sec_n(4);
      ovr = 1; cyc(4); ms_n(6); ovr = 0; cyc(4);
      burst_pulse();
      sec_n(5); chk("R8 sustain reloaded, still on", out_w, 1'b1);
      sec_n(1); chk("R8 sustain reload expires", out_w, 1'b0);
      // sustain armed but no burst boundary yet: original count stands
      touch_pulse(); sec_n(4);
      ovr = 1; cyc(4); ms_n(6); ovr = 0; cyc(4);
      sec_n(1); chk("R8 no reload before burst", out_w, 1'b1);
      sec_n(1); chk("R8 original expiry without burst", out_w, 1'b0);
      burst_pulse();
      chk("R8 sustain while off stays off", out_w, 1'b0);
   endtask

   task automatic t_short;
      dsel = 2'd2; act_low = 0; cyc(1);
      touch_pulse(); sec_n(4);
      ovr = 1; cyc(4); ms_n(3); ovr = 0; cyc(4);
      burst_pulse();
      sec_n(1); chk("R9 short pulse, on before expiry", out_w, 1'b1);
      sec_n(1); chk("R9 short pulse, no reload", out_w, 1'b0);
   endtask

   task automatic t_cancel;
      int hi;
      dsel = 2'd2; act_low = 0; cyc(1);
      touch_pulse();
      ovr = 1; cyc(4); ms_n(9);
      chk("R10 below cancel no inhibit", inh_w, 1'b0);
      chk("R10 below cancel still on", out_w, 1'b1);
      ms_n(1);
      chk("R10 cancel raises inhibit", inh_w, 1'b1);
      chk("R10 cancel forces off", out_w, 1'b0);
      touch_pulse();
      chk("R10 touch ignored while inhibited", out_w, 1'b0);
      ovr = 0;
      hi = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (recal_w) hi++;
      end
      n_chk++;
      if (hi != 1) begin
         n_bad++;
         $display("FAIL R11 recal cycles actual=%0d expected=1", hi);
      end
      chk("R11 inhibit released", inh_w, 1'b0);
      chk("R11 output stays off", out_w, 1'b0);
      touch_pulse();
      chk("R11 touch works after release", out_w, 1'b1);
      touch_pulse();
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_toggle();
      t_polarity();
      t_presets();
      t_user();
      t_mult();
      t_sustain();
      t_short();
      t_cancel();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule